// File: doc/BRIEF.md
# Parity-Checked Instruction Scratchpad with Backup Refetch

This block is an instruction scratchpad controller for a small embedded core. Each stored instruction word carries one even-parity bit, which is checked on every fetch. Parity detects single-bit upsets but cannot locate them. A second copy of every entry is therefore kept in a reserved region of main memory. When a fetch finds a parity mismatch, the controller stalls the core and reads the clean copy from that region. It then rewrites the damaged entry and hands the clean word to the core.

The core only reads the array, so the backup copy never goes stale. The array is written during program load through a fill port. Every fill is mirrored to the backup region in the same cycle, with its parity bit attached. A fault-injection port lets a test flip chosen bits of a stored entry. A saturating error counter, the index of the last failing entry and a sticky unrecoverable flag are exposed for test visibility.

Top module: `spm_parity_refetch`

## Requirements
- R1: After reset, fetchStall, fetchValid, memReq, bkWrEn and fatalErr are 0 and errCount is 0.
- R2: A fetch request is accepted on a clock edge where fetchStall is low. For an entry with good parity, fetchValid is 1 and fetchData holds the stored 32-bit word in the cycle after acceptance, with fetchStall low.
- R3: A fill accepted while fetchStall is low stores the word in the array together with its even-parity bit. In the same cycle it drives bkWrEn=1, bkWrAddr = BACKUP_BASE + index and bkWrData = {parity, data}, where bit 32 is the parity bit, equal to the XOR of the 32 data bits.
- R4: When the fetched entry has an odd number of ones across its 33 bits, the response cycle shows fetchValid=0 and fetchStall=1. In the next cycle memReq is 1 for exactly one cycle, with memAddr = BACKUP_BASE + index.
- R5: fetchStall stays 1 from the detection cycle through the cycle in which the backup response arrives. Fetch requests made while it is high are not accepted.
- R6: When the backup response (memRvalid, with memRdata in the {parity, data} layout) has good parity, fetchValid is 1 in that same cycle and fetchData is the backup data word. The entry is rewritten, so a later fetch of it returns the word with no new error.
- R7: Each parity error detected on a fetch adds 1 to errCount, which saturates at its maximum value. errAddr takes the failing index.
- R8: A backup response with bad parity sets fatalErr, which stays set until reset. That fetch ends without fetchValid, the entry is not rewritten, and the controller returns to idle.
- R9: Flipping an even number of bits of an entry goes undetected: the fetch returns the altered data word with fetchValid=1 and errCount unchanged.
- R10: An injEn pulse XORs injMask (bit 32 addresses the parity bit) into the entry at injAddr on that clock edge.
- R11: A fill attempted while fetchStall is 1 is ignored. bkWrEn stays 0 and the array entry keeps its old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Core fetch request |
| fetchAddr | input | 10 | Scratchpad word index to fetch |
| fetchData | output | 32 | Returned instruction word |
| fetchValid | output | 1 | fetchData is valid this cycle |
| fetchStall | output | 1 | Core must wait; requests are not accepted |
| fillEn | input | 1 | Load-time write strobe |
| fillAddr | input | 10 | Load-time write index |
| fillData | input | 32 | Load-time write word |
| bkWrEn | output | 1 | Mirror write to the backup region |
| bkWrAddr | output | 32 | Main-memory word address of the mirror write |
| bkWrData | output | 33 | Mirror word, {parity, data} |
| memReq | output | 1 | One-cycle backup read request |
| memAddr | output | 32 | Main-memory word address of the backup read |
| memRdata | input | 33 | Backup read data, {parity, data} |
| memRvalid | input | 1 | Backup read data is valid |
| injEn | input | 1 | Fault-injection strobe |
| injAddr | input | 10 | Entry to corrupt |
| injMask | input | 33 | Bits to flip in the entry |
| errCount | output | 8 | Saturating count of detected fetch errors |
| errAddr | output | 10 | Index of the last failing entry |
| fatalErr | output | 1 | Sticky unrecoverable-error flag |

## Verification
A clean fetch is due one cycle after the accepting edge. A detected error shows in that same cycle as a stall with no valid, and the backup request follows one cycle later. The corrected word appears in the very cycle the bench's memory model raises memRvalid, and the fatal flag appears on the edge after it. The bench drives inputs on falling edges and samples 2 ns later. Each check thus reads the state left by the previous rising edge together with the inputs of the current cycle. During a recovery, the bench walks cycle by cycle against its own model: it checks the stall level, the request address and the blocked fill in every cycle until the response, then checks the cycle after it.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} spmState_t;

  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic rdEn;      // read array entry at fetchAddr
    logic fillWr;    // write fill word (and mirror it)
    logic latchErr;  // record a detected fetch error
    logic refWr;     // rewrite failing entry with backup word
    logic setFatal;  // backup copy was also bad
  } spmStrobe_t;
endpackage

// File: rtl/spm_datapath.sv
module spm_datapath
  import spm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int MEM_AW = 32,
  parameter logic [MEM_AW-1:0] BACKUP_BASE = 32'h0001_0000,
  parameter int CNT_W  = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spmStrobe_t        strb,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [WORD_W-1:0] injMask,
  input  logic [WORD_W-1:0] memRdata,
  output logic              rdPend,
  output logic              rdBad,
  output logic              refBad,
  output logic [DATA_W-1:0] fetchData,
  output logic [MEM_AW-1:0] memAddr,
  output logic [MEM_AW-1:0] bkWrAddr,
  output logic [WORD_W-1:0] bkWrData,
  output logic [CNT_W-1:0]  errCount,
  output logic [ADDR_W-1:0] errAddr,
  output logic              fatalErr
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic [ADDR_W-1:0] rdAddr;
  logic [WORD_W-1:0] fillWord;

  assign fillWord = {^fillData, fillData};

  // Single write port with priority: recovery, fill, fault injection.
  always_ff @(posedge clk) begin
    if (strb.refWr)       mem[errAddr] <= memRdata;
    else if (strb.fillWr) mem[fillAddr] <= fillWord;
    else if (injEn)       mem[injAddr] <= mem[injAddr] ^ injMask;
    if (strb.rdEn) begin
      rdWord <= mem[fetchAddr];
      rdAddr <= fetchAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      errCount <= '0;
      errAddr  <= '0;
      fatalErr <= 1'b0;
    end else begin
      rdPend <= strb.rdEn;
      if (strb.latchErr) begin
        errAddr <= rdAddr;
        if (errCount != {CNT_W{1'b1}}) errCount <= errCount + 1'b1;
      end
      if (strb.setFatal) fatalErr <= 1'b1;
    end
  end

  assign rdBad     = ^rdWord;
  assign refBad    = ^memRdata;
  assign fetchData = strb.refWr ? memRdata[DATA_W-1:0] : rdWord[DATA_W-1:0];
  assign memAddr   = BACKUP_BASE + MEM_AW'(errAddr);
  assign bkWrAddr  = BACKUP_BASE + MEM_AW'(fillAddr);
  assign bkWrData  = fillWord;

  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |=> fatalErr); // R8
  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    errCount >= $past(errCount)); // R7
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.refWr, strb.fillWr})); // R11
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchReq,
  input  logic       fillEn,
  input  logic       rdPend,
  input  logic       rdBad,
  input  logic       memRvalid,
  input  logic       refBad,
  output spmStrobe_t strb,
  output logic       fetchValid,
  output logic       fetchStall,
  output logic       memReq
);
  spmState_t state, stateNxt;
  logic detect;

  assign detect     = (state == ST_IDLE) && rdPend && rdBad;
  assign fetchStall = (state != ST_IDLE) || detect;
  assign memReq     = (state == ST_REQ);

  always_comb begin
    strb          = '0;
    strb.rdEn     = fetchReq && !fetchStall;
    strb.fillWr   = fillEn && !fetchStall;
    strb.latchErr = detect;
    strb.refWr    = (state == ST_WAIT) && memRvalid && !refBad;
    strb.setFatal = (state == ST_WAIT) && memRvalid && refBad;
  end

  assign fetchValid = ((state == ST_IDLE) && rdPend && !rdBad) || strb.refWr;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (detect) stateNxt = ST_REQ;
      ST_REQ:  stateNxt = ST_WAIT;
      ST_WAIT: if (memRvalid) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  AST_REQ_AFTER_DETECT: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && rdBad && !fetchValid && !memReq && !(state == ST_WAIT)) |=> memReq); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R4
  AST_STALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> fetchStall); // R5
endmodule

// File: rtl/spm_parity_refetch.sv
module spm_parity_refetch
  import spm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int MEM_AW = 32,
  parameter logic [MEM_AW-1:0] BACKUP_BASE = 32'h0001_0000,
  parameter int CNT_W  = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [DATA_W-1:0] fetchData,
  output logic              fetchValid,
  output logic              fetchStall,
  input  logic              fillEn,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              bkWrEn,
  output logic [MEM_AW-1:0] bkWrAddr,
  output logic [WORD_W-1:0] bkWrData,
  output logic              memReq,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memRvalid,
  input  logic              injEn,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [WORD_W-1:0] injMask,
  output logic [CNT_W-1:0]  errCount,
  output logic [ADDR_W-1:0] errAddr,
  output logic              fatalErr
);
  spmStrobe_t strb;
  logic rdPend, rdBad, refBad;

  spm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fillEn(fillEn),
    .rdPend(rdPend), .rdBad(rdBad), .memRvalid(memRvalid), .refBad(refBad),
    .strb(strb), .fetchValid(fetchValid), .fetchStall(fetchStall), .memReq(memReq)
  );

  spm_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW),
    .BACKUP_BASE(BACKUP_BASE), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchAddr(fetchAddr),
    .fillAddr(fillAddr), .fillData(fillData), .injEn(injEn), .injAddr(injAddr),
    .injMask(injMask), .memRdata(memRdata), .rdPend(rdPend), .rdBad(rdBad),
    .refBad(refBad), .fetchData(fetchData), .memAddr(memAddr),
    .bkWrAddr(bkWrAddr), .bkWrData(bkWrData), .errCount(errCount),
    .errAddr(errAddr), .fatalErr(fatalErr)
  );

  assign bkWrEn = strb.fillWr;
endmodule

// File: tb/tb_spm_parity_refetch.sv
`timescale 1ns/1ps
module tb_spm_parity_refetch;
  localparam int DEPTH = 1024;
  localparam int AW = 10;
  localparam int CW = 4;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam int LAT = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic fetchReq = 0, fillEn = 0, injEn = 0, memRvalid = 0;
  logic [AW-1:0] fetchAddr = '0, fillAddr = '0, injAddr = '0;
  logic [31:0] fillData = '0;
  logic [32:0] injMask = '0, memRdata = '0;
  logic [31:0] fetchData, bkWrAddr, memAddr;
  logic fetchValid, fetchStall, bkWrEn, memReq, fatalErr;
  logic [32:0] bkWrData;
  logic [CW-1:0] errCount;
  logic [AW-1:0] errAddr;

  int total = 0, fails = 0, expCnt = 0;
  logic [32:0] bk [DEPTH];
  logic [31:0] img [DEPTH];
  logic [32:0] rspFlip = '0;
  int rspCnt = 0;
  logic [AW-1:0] rspIdx = '0;

  always #5 clk = ~clk;

  spm_parity_refetch #(.BACKUP_BASE(BASE), .CNT_W(CW)) dut (.*);

  // Backup-region memory model
  always @(posedge clk) if (bkWrEn) bk[AW'(bkWrAddr - BASE)] <= bkWrData;
  always @(negedge clk) begin
    memRvalid = 1'b0;
    if (rspCnt > 0) begin
      rspCnt = rspCnt - 1;
      if (rspCnt == 0) begin memRvalid = 1'b1; memRdata = bk[rspIdx] ^ rspFlip; end
    end
    if (memReq) begin rspCnt = LAT; rspIdx = AW'(memAddr - BASE); end
  end

  function automatic logic [31:0] pat(int i);
    return 32'h1357_9BDF ^ (i * 32'h0101_0101);
  endfunction

  function automatic int satExp();
    return (expCnt > 15) ? 15 : expCnt;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic fill(input int i, input logic [31:0] d);
    @(negedge clk); fillEn = 1; fillAddr = AW'(i); fillData = d; #2;
    chk(bkWrEn == 1, "R3 mirror enable", 64'(bkWrEn), 1);
    chk(bkWrAddr == BASE + i, "R3 mirror address", 64'(bkWrAddr), 64'(BASE + i));
    chk(bkWrData == {^d, d}, "R3 mirror word", 64'(bkWrData), 64'({^d, d}));
    img[i] = d;
    @(negedge clk); fillEn = 0;
  endtask

  task automatic fetchClean(input int i, input logic [31:0] exp, input string req);
    @(negedge clk); fetchReq = 1; fetchAddr = AW'(i);
    @(negedge clk); fetchReq = 0; #2;
    chk(fetchValid == 1 && fetchStall == 0, req, {fetchValid, fetchStall}, 2'b10);
    chk(fetchData == exp, req, 64'(fetchData), 64'(exp));
  endtask

  task automatic inject(input int i, input logic [32:0] m);
    @(negedge clk); injEn = 1; injAddr = AW'(i); injMask = m;
    @(negedge clk); injEn = 0;
  endtask

  // Fetch of a corrupted entry; badBk corrupts the backup response.
  task automatic fetchRecover(input int i, input bit badBk, input int blockedFill);
    bit done = 0;
    @(negedge clk); fetchReq = 1; fetchAddr = AW'(i);
    @(negedge clk); fetchAddr = AW'(i + 1); #2;
    chk(fetchValid == 0 && fetchStall == 1, "R4 detect cycle", {fetchValid, fetchStall}, 2'b01);
    expCnt++;
    for (int n = 0; n < 40 && !done; n++) begin
      @(negedge clk);
      if (n == 1 && blockedFill >= 0) begin
        fillEn = 1; fillAddr = AW'(blockedFill); fillData = 32'hDEAD_BEEF;
      end else fillEn = 0;
      #2;
      chk(fetchStall == 1, "R5 stall held", 64'(fetchStall), 1);
      if (n == 0) begin
        chk(memReq == 1, "R4 request", 64'(memReq), 1);
        chk(memAddr == BASE + i, "R4 backup address", 64'(memAddr), 64'(BASE + i));
      end else chk(memReq == 0, "R4 single request", 64'(memReq), 0);
      if (fillEn) chk(bkWrEn == 0, "R11 fill blocked", 64'(bkWrEn), 0);
      if (memRvalid) begin
        done = 1;
        if (badBk) chk(fetchValid == 0, "R8 no valid", 64'(fetchValid), 0);
        else begin
          chk(fetchValid == 1, "R6 valid", 64'(fetchValid), 1);
          chk(fetchData == img[i], "R6 corrected data", 64'(fetchData), 64'(img[i]));
        end
      end
    end
    chk(done, "R4 response reached", 64'(done), 1);
    @(negedge clk); fetchReq = 0; fillEn = 0; #2;
    chk(fetchStall == 0 && fetchValid == 0, "R5 held request not taken", {fetchStall, fetchValid}, 0);
    chk(errCount == satExp(), "R7 count", 64'(errCount), 64'(satExp()));
    chk(errAddr == AW'(i), "R7 address", 64'(errAddr), 64'(i));
    if (badBk) chk(fatalErr == 1, "R8 fatal set", 64'(fatalErr), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk({fetchStall, fetchValid, memReq, bkWrEn, fatalErr} == 0, "R1 reset outputs",
        {fetchStall, fetchValid, memReq, bkWrEn, fatalErr}, 0);
    chk(errCount == 0, "R1 reset count", 64'(errCount), 0);
    @(negedge clk); rstN = 1;

    for (int i = 0; i < 12; i++) fill(i, pat(i));
    fill(DEPTH - 1, 32'h8000_0001);
    fill(11, 32'h0000_0007);                       // odd number of ones
    fetchClean(2, pat(2), "R2 clean fetch");
    fetchClean(11, 32'h0000_0007, "R2 odd-weight word");
    fetchClean(DEPTH - 1, 32'h8000_0001, "R2 last entry");

    inject(3, 33'h0_0000_0080);                    // R10 single data bit
    fetchRecover(3, 0, 8);
    fetchClean(8, pat(8), "R11 entry kept");
    fetchClean(3, pat(3), "R6 rewritten entry");
    chk(errCount == satExp(), "R6 no new error", 64'(errCount), 64'(satExp()));

    inject(4, 33'h1_0000_0000);                    // R10 parity bit only
    fetchRecover(4, 0, -1);

    inject(6, 33'h0_0000_0300);                    // R9 two bits
    fetchClean(6, pat(6) ^ 32'h300, "R9 undetected double flip");
    chk(errCount == satExp(), "R9 count unchanged", 64'(errCount), 64'(satExp()));
    fill(6, pat(6));

    inject(5, 33'h0_0001_0000);
    rspFlip = 33'h0_0000_0001;
    fetchRecover(5, 1, -1);                        // R8
    rspFlip = '0;
    fetchRecover(5, 0, -1);                        // still corrupt: detected again
    chk(fatalErr == 1, "R8 fatal sticky", 64'(fatalErr), 1);

    for (int k = 0; k < 14; k++) begin             // R7 saturation
      inject(k % 10, 33'h0_0400_0000);
      fetchRecover(k % 10, 0, -1);
    end
    chk(errCount == 4'hF, "R7 saturated", 64'(errCount), 15);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule